// File: doc/BRIEF.md
# Streaming Multiplier with Fixed Short Operand

This block forms the product of a short factor K, held inside the block, and a long factor N that arrives as a stream of small digits, lowest digit first. N has no length limit. Every accepted digit of N returns a digit of the product of the same width in the same clock cycle. The product therefore leaves the block as a stream that runs alongside the input. The running partial product is held as two vectors plus a one-bit carry. Each step passes through one layer of full adders and a carry ripple only as wide as one digit, and never through a carry chain as wide as K.

A caller loads K, which also zeroes the partial product. It then presents the digits of N with a valid strobe and collects one product digit for each digit it presents. After the last digit of N, the caller issues flush steps. These feed zero into the block and push out the upper part of the product. The parameter `DIGIT_W` selects a digit of one bit or two bits. In the two-bit mode the block keeps a precomputed copy of 3K, so it can pick any multiple from 0 to 3K without doing an addition.

Top module: `csmul_stream`

## Requirements
- R1: When `k_load` is high, `k_value` is stored as K on the next edge. The sum vector, carry vector and carry bit are zeroed. `out_valid` stays low in that cycle, even if `in_valid` or `flush` is also high.
- R2: With `k_load`, `in_valid` and `flush` all low, `out_valid` is low and the partial product keeps its value.
- R3: A cycle with `in_valid` high and `k_load` low consumes `in_digit` and raises `out_valid` in that same cycle. `out_digit` gives the next `DIGIT_W` bits of N*K, least significant first. Bit j of `out_digit` in step i has weight 2^(i*DIGIT_W+j).
- R4: A cycle with `flush` high and `in_valid` and `k_load` low is a step that adds zero. `in_digit` has no effect on its output or on the state it leaves behind.
- R5: Assume the stream of N is L digits long. After the last digit, KW/DIGIT_W flush steps emit the remaining bits of N*K, so the product is L*DIGIT_W+KW bits in total. Any flush step after that emits zero.
- R6: `DIGIT_W` equal to 1 or 2 gives a product that is exact for every K and N.
- R7: The top `DIGIT_W` bits of the sum vector and of the carry vector are always zero, so the redundant state never overflows.
- R8: Reset zeroes K and the partial product, so a flush issued straight after reset emits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| k_load | input | 1 | Store a new K and clear the partial product |
| k_value | input | KW | Value of K |
| in_valid | input | 1 | `in_digit` carries the next digit of N |
| in_digit | input | DIGIT_W | Digit of N, least significant first |
| flush | input | 1 | Step with a zero digit to drain the upper product bits |
| out_valid | output | 1 | A product digit is present in this cycle |
| out_digit | output | DIGIT_W | Product digit |

## Verification
With a 4-bit K, the bench sweeps every K against every 8-bit N in both digit widths. The sweep covers K of zero, one, all ones and K with a single bit set. These cases separate a wrong multiple choice in the two-bit selector from a lost carry-save bit, and from a carry bit that is dropped between steps. Long streams of random 40-bit N, with idle gaps inserted at random points, show that idle cycles leave the state untouched and that the low carry bit survives many steps. The bench also checks the following cases:
- flush steps with garbage on `in_digit`;
- a reload issued while a stream is partly done;
- a load issued at the same time as valid input.

Together these show that a flush ignores its digit, that a reload clears everything, and that a load takes priority over a data step.

// File: rtl/csmul_pkg.sv
package csmul_pkg;

    typedef enum logic [1:0] {
        STEP_IDLE  = 2'd0,
        STEP_LOAD  = 2'd1,
        STEP_DATA  = 2'd2,
        STEP_FLUSH = 2'd3
    } step_kind_e;

    function automatic int unsigned acc_width(input int unsigned kw, input int unsigned dw);
        return kw + dw + 1;
    endfunction

endpackage

// File: rtl/csmul_addend.sv
// Holds K (and 3K in two-bit mode) and selects digit*K without an adder in the step path.
module csmul_addend #(
    parameter int unsigned KW      = 8,
    parameter int unsigned DIGIT_W = 1,
    localparam int unsigned AW     = KW + DIGIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               k_load,
    input  logic [KW-1:0]      k_value,
    input  logic [DIGIT_W-1:0] digit,
    output logic [AW-1:0]      addend
);

    logic [KW-1:0] k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (k_load) k_d = k_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    generate
        if (DIGIT_W == 1) begin : g_one
            always_comb begin
                addend = digit[0] ? {1'b0, k_q} : '0;
            end
        end else if (DIGIT_W == 2) begin : g_two
            logic [KW+1:0] k3_d, k3_q;

            always_comb begin
                k3_d = k3_q;
                if (k_load) k3_d = {2'b00, k_value} + {1'b0, k_value, 1'b0};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) k3_q <= '0;
                else        k3_q <= k3_d;
            end

            always_comb begin
                unique case (digit)
                    2'd0:    addend = '0;
                    2'd1:    addend = {2'b00, k_q};
                    2'd2:    addend = {1'b0, k_q, 1'b0};
                    default: addend = k3_q;
                endcase
            end
        end else begin : g_bad
            $error("csmul_addend: DIGIT_W must be 1 or 2");
        end
    endgenerate

endmodule

// File: rtl/csmul_csa.sv
// One full-adder layer: three vectors in, sum plus shifted majority out.
// The free bit 0 of the carry output takes a one-bit carry from the previous step.
module csmul_csa #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_col
        assign sum[i] = a[i] ^ b[i] ^ c[i];
        if (i < W - 1) begin : g_maj
            assign carry[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        end
    end

endmodule

// File: rtl/csmul_lowadd.sv
// Digit-wide ripple adder that turns the low columns of the redundant sum into exact bits.
module csmul_lowadd #(
    parameter int unsigned DIGIT_W = 1
) (
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    output logic [DIGIT_W-1:0] y,
    output logic               cout
);

    logic [DIGIT_W:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < DIGIT_W; i++) begin : g_bit
        assign y[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end

    assign cout = c[DIGIT_W];

endmodule

// File: rtl/csmul_stream.sv
module csmul_stream #(
    parameter int unsigned KW      = 8,
    parameter int unsigned DIGIT_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               k_load,
    input  logic [KW-1:0]      k_value,
    input  logic               in_valid,
    input  logic [DIGIT_W-1:0] in_digit,
    input  logic               flush,
    output logic               out_valid,
    output logic [DIGIT_W-1:0] out_digit
);
    import csmul_pkg::*;

    localparam int unsigned AW = KW + DIGIT_W;
    localparam int unsigned W  = acc_width(KW, DIGIT_W);

    typedef struct packed {
        logic [W-1:0] sum;
        logic [W-1:0] car;
        logic         cin;
    } acc_t;

    acc_t                acc_d, acc_q;
    step_kind_e          kind;
    logic [DIGIT_W-1:0]  digit_eff;
    logic [AW-1:0]       addend;
    logic [W-1:0]        addend_w;
    logic [W-1:0]        csa_sum, csa_car;
    logic [DIGIT_W-1:0]  low_bits;
    logic                low_cout;

    always_comb begin
        if (k_load)        kind = STEP_LOAD;
        else if (in_valid) kind = STEP_DATA;
        else if (flush)    kind = STEP_FLUSH;
        else               kind = STEP_IDLE;
        digit_eff = (kind == STEP_DATA) ? in_digit : '0;
    end

    csmul_addend #(.KW(KW), .DIGIT_W(DIGIT_W)) u_addend (
        .clk     (clk),
        .rst_n   (rst_n),
        .k_load  (k_load),
        .k_value (k_value),
        .digit   (digit_eff),
        .addend  (addend)
    );

    assign addend_w = {{(W-AW){1'b0}}, addend};

    csmul_csa #(.W(W)) u_csa (
        .a     (acc_q.sum),
        .b     (acc_q.car),
        .c     (addend_w),
        .cin   (acc_q.cin),
        .sum   (csa_sum),
        .carry (csa_car)
    );

    csmul_lowadd #(.DIGIT_W(DIGIT_W)) u_low (
        .a    (csa_sum[DIGIT_W-1:0]),
        .b    (csa_car[DIGIT_W-1:0]),
        .y    (low_bits),
        .cout (low_cout)
    );

    always_comb begin
        acc_d     = acc_q;
        out_valid = 1'b0;
        out_digit = '0;
        unique case (kind)
            STEP_LOAD: acc_d = '0;
            STEP_DATA, STEP_FLUSH: begin
                out_valid = 1'b1;
                out_digit = low_bits;
                acc_d.sum = csa_sum >> DIGIT_W;
                acc_d.car = csa_car >> DIGIT_W;
                acc_d.cin = low_cout;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

endmodule

// File: rtl/csmul_stream_chk.sv
module csmul_stream_chk #(
    parameter int unsigned W       = 10,
    parameter int unsigned DIGIT_W = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               k_load,
    input logic               in_valid,
    input logic               flush,
    input logic               out_valid,
    input logic [DIGIT_W-1:0] out_digit,
    input logic [W-1:0]       sum_q,
    input logic [W-1:0]       car_q,
    input logic               cin_q
);

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        k_load |=> (sum_q == '0 && car_q == '0 && !cin_q)); // R1

    AST_LOAD_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        k_load |-> !out_valid); // R1

    AST_IDLE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |-> !out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!k_load && !in_valid && !flush) |=> ($stable(sum_q) && $stable(car_q) && $stable(cin_q))); // R2

    AST_DATA_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !k_load) |-> out_valid); // R3

    AST_DRAINED_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !in_valid && !k_load && sum_q == '0 && car_q == '0 && !cin_q)
        |-> (out_digit == '0)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_q[W-1 -: DIGIT_W] == '0 && car_q[W-1 -: DIGIT_W] == '0)); // R7

endmodule

bind csmul_stream csmul_stream_chk #(.W(W), .DIGIT_W(DIGIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .k_load    (k_load),
    .in_valid  (in_valid),
    .flush     (flush),
    .out_valid (out_valid),
    .out_digit (out_digit),
    .sum_q     (acc_q.sum),
    .car_q     (acc_q.car),
    .cin_q     (acc_q.cin)
);

// File: tb/csmul_stream_bench.sv
module csmul_stream_bench;

    localparam int unsigned KW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // one-bit digit instance
    logic          a_kl = 0, a_iv = 0, a_fl = 0, a_id = 0;
    logic [KW-1:0] a_kv = '0;
    logic          a_ov;
    logic          a_od;
    // two-bit digit instance
    logic          b_kl = 0, b_iv = 0, b_fl = 0;
    logic [1:0]    b_id = '0;
    logic [KW-1:0] b_kv = '0;
    logic          b_ov;
    logic [1:0]    b_od;

    csmul_stream #(.KW(KW), .DIGIT_W(1)) u_csmul_stream (
        .clk(clk), .rst_n(rst_n), .k_load(a_kl), .k_value(a_kv),
        .in_valid(a_iv), .in_digit(a_id), .flush(a_fl),
        .out_valid(a_ov), .out_digit(a_od)
    );

    csmul_stream #(.KW(KW), .DIGIT_W(2)) u_csmul_stream_d2 (
        .clk(clk), .rst_n(rst_n), .k_load(b_kl), .k_value(b_kv),
        .in_valid(b_iv), .in_digit(b_id), .flush(b_fl),
        .out_valid(b_ov), .out_digit(b_od)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one-bit instance: drive a step at the falling edge, sample 1 ns before the rising edge
    task automatic step_a(input logic kl, input logic [KW-1:0] kv, input logic iv,
                          input logic d, input logic fl, output logic ov, output logic od);
        @(negedge clk);
        a_kl = kl; a_kv = kv; a_iv = iv; a_id = d; a_fl = fl;
        #1;
        ov = a_ov; od = a_od;
    endtask

    task automatic step_b(input logic kl, input logic [KW-1:0] kv, input logic iv,
                          input logic [1:0] d, input logic fl, output logic ov, output logic [1:0] od);
        @(negedge clk);
        b_kl = kl; b_kv = kv; b_iv = iv; b_id = d; b_fl = fl;
        #1;
        ov = b_ov; od = b_od;
    endtask

    task automatic run_a(input logic [KW-1:0] k, input logic [63:0] n, input int len, input bit gaps);
        logic ov, od;
        logic [63:0] got, exp, mask;
        got = '0;
        step_a(1, k, 1, 1, 1, ov, od);
        if (ov !== 1'b0) chk("R1 load wins over data", {63'b0, ov}, 64'd0);
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                step_a(0, '0, 0, 1'($urandom), 0, ov, od);
                if (ov !== 1'b0) chk("R2 idle emits nothing", {63'b0, ov}, 64'd0);
            end
            step_a(0, '0, 1, n[i], 0, ov, od);
            if (ov !== 1'b1) chk("R3 data step valid", {63'b0, ov}, 64'd1);
            got[i] = od;
        end
        for (int j = 0; j < KW; j++) begin
            step_a(0, '0, 0, 1'($urandom), 1, ov, od);   // R4: garbage digit on flush
            got[len + j] = od;
        end
        mask = (64'd1 << (len + KW)) - 64'd1;
        exp  = (64'(k) * n) & mask;
        chk("R3 R4 R5 R6 product one-bit digits", got, exp);
        step_a(0, '0, 0, 1, 1, ov, od);
        if (od !== 1'b0) chk("R5 post-drain flush zero", {63'b0, od}, 64'd0);
    endtask

    task automatic run_b(input logic [KW-1:0] k, input logic [63:0] n, input int digits, input bit gaps);
        logic ov;
        logic [1:0] od;
        logic [63:0] got, exp, mask;
        got = '0;
        step_b(1, k, 1, 2'd3, 1, ov, od);
        if (ov !== 1'b0) chk("R1 load wins over data", {63'b0, ov}, 64'd0);
        for (int i = 0; i < digits; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                step_b(0, '0, 0, 2'($urandom), 0, ov, od);
                if (ov !== 1'b0) chk("R2 idle emits nothing", {63'b0, ov}, 64'd0);
            end
            step_b(0, '0, 1, n[2*i +: 2], 0, ov, od);
            if (ov !== 1'b1) chk("R3 data step valid", {63'b0, ov}, 64'd1);
            got[2*i +: 2] = od;
        end
        for (int j = 0; j < KW / 2; j++) begin
            step_b(0, '0, 0, 2'($urandom), 1, ov, od);
            got[2*(digits + j) +: 2] = od;
        end
        mask = (64'd1 << (2*digits + KW)) - 64'd1;
        exp  = (64'(k) * n) & mask;
        chk("R3 R4 R5 R6 product two-bit digits", got, exp);
        step_b(0, '0, 0, 2'd3, 1, ov, od);
        if (od !== 2'd0) chk("R5 post-drain flush zero", {62'b0, od}, 64'd0);
    endtask

    initial begin : watchdog
        #(4 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic ov, od;
        logic ovb;
        logic [1:0] odb;
        logic [63:0] n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state, then R2 idle
        step_a(0, '0, 0, 0, 0, ov, od);
        chk("R2 idle after reset", {63'b0, ov}, 64'd0);
        step_a(0, '0, 0, 1, 1, ov, od);
        chk("R8 flush after reset valid", {63'b0, ov}, 64'd1);
        chk("R8 flush after reset zero", {63'b0, od}, 64'd0);
        step_b(0, '0, 0, 2'd3, 1, ovb, odb);
        chk("R8 two-bit flush after reset zero", {62'b0, odb}, 64'd0);

        // R1: reload mid-stream clears the partial product
        step_a(1, 4'hF, 0, 0, 0, ov, od);
        for (int i = 0; i < 3; i++) step_a(0, '0, 1, 1, 0, ov, od);
        run_a(4'h9, 64'hB5, 8, 0);
        step_b(1, 4'hF, 0, 2'd0, 0, ovb, odb);
        for (int i = 0; i < 2; i++) step_b(0, '0, 1, 2'd3, 0, ovb, odb);
        run_b(4'h9, 64'hB5, 4, 0);

        // R6: exhaustive sweep over every K and every 8-bit N
        for (int k = 0; k < 16; k++) begin
            for (int v = 0; v < 256; v++) begin
                run_a(4'(k), 64'(v), 8, 0);
                run_b(4'(k), 64'(v), 4, 0);
            end
        end

        // R2 R3: long random streams with idle gaps
        for (int t = 0; t < 40; t++) begin
            n = {$urandom, $urandom} & 64'hFF_FFFF_FFFF;
            run_a(4'($urandom), n, 40, 1);
            run_b(4'($urandom), n, 20, 1);
        end
        run_a(4'hF, 64'hFF_FFFF_FFFF, 40, 1);
        run_b(4'hF, 64'hFF_FFFF_FFFF, 20, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule